// File: doc/BRIEF.md
# NAND Operation Trigger Engine

This block starts one NAND bus operation at a time and reports when that operation has finished. Software sets it up through a small 16-bit register port. The registers hold the command value, the address value, the buffer and chip selection, a configuration word, the write-protect mode and a window of unlocked blocks. Software then writes one trigger bit that names the operation. The engine offers the operation to a flash-side stub through a valid/ready handshake. It then waits for the stub's done pulse, and after that waits for the ready/busy line to show ready. Only then does it raise a sticky completion flag, which can also drive a maskable interrupt.

The flash-side handshake follows the usual stream rules. `nand_op_valid` rises once a trigger has been accepted. From that point, `nand_op_code` and `nand_op_data` hold steady until a cycle in which `nand_op_ready` is also high. The stub may keep ready low for any number of cycles. The transfer takes place on the first rising edge where valid and ready are both high. The completion path (`nand_done`, `nand_rb`) and the register port are plain signals with no handshake.

The engine also has the following controls:
- A self-clearing soft reset, which aborts any operation in progress.
- Chip-enable outputs, active low, one per chip.
- Write protection. Program requests and erase commands are refused unless an unlocked window covers the target block.
- A lock-tight mode, which freezes the protection setting until the next reset.

Top module: `nand_op_engine`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, `nand_op_valid` is 0 and all `nand_ce_n` bits are 1.
- R2: A write to the trigger register (offset 0) with exactly one of bits 5:0 set starts an operation while the engine is idle. Bit0 is a command cycle and carries the command register (offset 1). Bit1 is an address cycle and carries the address register (offset 2). Bit2 is program, bit3 is page read, bit4 is read ID and bit5 is read status; these four carry 0. `nand_op_code` shows the same one-hot bit. Valid and payload hold stable until ready is seen. While busy, bits 5:0 of the trigger register read back the running operation.
- R3: Bit 15 of the trigger register (done) sets only after the done pulse has been received and then `nand_rb` has been seen high. It then stays set. Writing 0 to bit 15 clears it, and writing 1 leaves it unchanged.
- R4: `irq` is high exactly while done is 1 and configuration bit 4 (interrupt mask) is 0.
- R5: A trigger write with a single one-hot bit while an operation runs starts nothing and sets the sticky fail flag at trigger bit 14. Writing 0 to bit 14 clears that flag.
- R6: A trigger write with none, or more than one, of bits 5:0 set starts no operation and sets no flag.
- R7: `nand_ce_n[i]` is 0 only when configuration bit 7 is 1 and the chip-select field (bits 6:5 of offset 3) equals i. All other bits are 1.
- R8: Writing 1 to configuration bit 6 (offset 4) does the following:
  - it starts a soft reset lasting RST_CYCLES cycles, during which bit 6 reads 1 and then clears itself;
  - it aborts any operation;
  - it clears done, fail and the write-protect register;
  - trigger writes made during the soft reset are ignored.
- R9: Two kinds of request are refused unless both of these hold: the write-protect register (offset 5) reads 3'b100 (unlock), and the address register lies between the window bounds at offsets 6 and 7, inclusive. The requests are a program trigger (bit2), and a command trigger whose command register holds 0x60 or 0xD0. A refused request sets fail, starts no operation and does not set done.
- R10: Once write-protect bit 0 (lock-tight) is set, writes to offset 5 are ignored until a hardware or soft reset.
- R11: The configuration register keeps bits 11:0 and the buffer register keeps bits 2:0 and 6:5; other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| nand_op_valid | output | 1 | Operation offered to the flash side |
| nand_op_ready | input | 1 | Flash side accepts the operation |
| nand_op_code | output | 6 | One-hot operation kind |
| nand_op_data | output | 16 | Command or address value |
| nand_done | input | 1 | One-cycle pulse: flash-side transfer finished |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |
| nand_ce_n | output | 4 | Active-low chip enables |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions take three things for granted:
- `nand_done` arrives only as a single-cycle pulse after the operation has been accepted.
- `nand_rb` is low from acceptance until some time after that pulse.
- Register writes are single-cycle strobes.

The bench's flash stub keeps to these rules. It drops ready/busy on each accepted operation, pulses done three cycles later, and releases ready/busy five cycles after the pulse. Ready is held low only in the abort scenario, where the stub therefore never sees a handshake.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;
  localparam int REG_W   = 16;
  localparam int OP_N    = 6;
  localparam int CFG_W   = 12;
  localparam int WP_W    = 3;

  typedef enum logic [2:0] {
    RA_TRIG = 3'd0,
    RA_CMD  = 3'd1,
    RA_ADDR = 3'd2,
    RA_BSEL = 3'd3,
    RA_CFG  = 3'd4,
    RA_WP   = 3'd5,
    RA_WLO  = 3'd6,
    RA_WHI  = 3'd7
  } reg_addr_e;

  localparam int OPB_CMD  = 0;
  localparam int OPB_ADR  = 1;
  localparam int OPB_PROG = 2;

  localparam int TRIG_DONE_B = 15;
  localparam int TRIG_FAIL_B = 14;

  localparam int CFG_MASK_B = 4;
  localparam int CFG_RST_B  = 6;
  localparam int CFG_CE_B   = 7;

  localparam int BSEL_BUF_W  = 3;
  localparam int BSEL_CS_LSB = 5;
  localparam int BSEL_CS_W   = 2;

  localparam int WPB_TIGHT = 0;
  localparam logic [WP_W-1:0] WP_OPEN = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT_DONE,
    ST_WAIT_RB
  } seq_st_e;
endpackage

// File: rtl/nand_eng_rstctl.sv
module nand_eng_rstctl #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start && !busy) cnt_q <= LOAD;
    else if (busy)           cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_RST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == CW'(1)) |=> !busy); // R8
endmodule

// File: rtl/nand_eng_guard.sv
module nand_eng_guard
  import nand_eng_pkg::*;
#(
  parameter logic [REG_W-1:0] ERASE_SETUP = 16'h0060,
  parameter logic [REG_W-1:0] ERASE_GO    = 16'h00D0
) (
  input  logic [OP_N-1:0]  req_op,
  input  logic [REG_W-1:0] cmd_val,
  input  logic [REG_W-1:0] blk,
  input  logic [WP_W-1:0]  wp_mode,
  input  logic [REG_W-1:0] win_lo,
  input  logic [REG_W-1:0] win_hi,
  output logic             refuse
);
  logic is_erase, is_prog, needs_guard, in_win, open_mode;

  always_comb begin
    is_erase    = req_op[OPB_CMD] && ((cmd_val == ERASE_SETUP) || (cmd_val == ERASE_GO));
    is_prog     = req_op[OPB_PROG];
    needs_guard = is_erase || is_prog;
    in_win      = (blk >= win_lo) && (blk <= win_hi);
    open_mode   = (wp_mode == WP_OPEN);
    refuse      = needs_guard && !(open_mode && in_win);
  end
endmodule

// File: rtl/nand_eng_seq.sv
module nand_eng_seq
  import nand_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [OP_N-1:0]  start_op,
  input  logic [REG_W-1:0] start_data,
  input  logic             op_ready,
  input  logic             nand_done,
  input  logic             nand_rb,
  output logic             op_valid,
  output logic [OP_N-1:0]  op_code,
  output logic [REG_W-1:0] op_data,
  output logic             idle,
  output logic             finish
);
  seq_st_e          st_q;
  logic [OP_N-1:0]  op_q;
  logic [REG_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      data_q <= '0;
    end else if (abort) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_ISSUE;
          op_q   <= start_op;
          data_q <= start_data;
        end
        ST_ISSUE:     if (op_ready)  st_q <= ST_WAIT_DONE;
        ST_WAIT_DONE: if (nand_done) st_q <= ST_WAIT_RB;
        ST_WAIT_RB: if (nand_rb) begin
          st_q <= ST_IDLE;
          op_q <= '0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign op_valid = (st_q == ST_ISSUE);
  assign op_code  = op_valid ? op_q : '0;
  assign op_data  = op_valid ? data_q : '0;
  assign idle     = (st_q == ST_IDLE);
  assign finish   = (st_q == ST_WAIT_RB) && nand_rb && !abort;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready && !abort) |=> (op_valid && $stable(op_code) && $stable(op_data))); // R2
  AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $onehot(op_code)); // R2
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !op_valid); // R8
endmodule

// File: rtl/nand_eng_regs.sv
module nand_eng_regs
  import nand_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             idle,
  input  logic             finish,
  input  logic [OP_N-1:0]  cur_op,
  input  logic             rst_busy,
  input  logic             refuse,
  output logic             start,
  output logic [REG_W-1:0] start_data,
  output logic             sw_rst_req,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] addr_q,
  output logic [WP_W-1:0]  wp_q,
  output logic [REG_W-1:0] wlo_q,
  output logic [REG_W-1:0] whi_q,
  output logic [CFG_W-1:0] cfg_q,
  output logic [BSEL_CS_W-1:0] cs_q,
  output logic             done_q,
  output logic             fail_q
);
  logic [BSEL_BUF_W-1:0] buf_q;
  logic wr_trig, trig_one, busy_hit, refused, wp_wr_ok;
  logic [CFG_W-1:0] cfg_rd;

  always_comb begin
    wr_trig    = reg_wr && (reg_addr == RA_TRIG);
    trig_one   = $onehot(reg_wdata[OP_N-1:0]);
    start      = wr_trig && trig_one && idle && !rst_busy && !refuse;
    busy_hit   = wr_trig && trig_one && !idle && !rst_busy;
    refused    = wr_trig && trig_one && idle && !rst_busy && refuse;
    sw_rst_req = reg_wr && (reg_addr == RA_CFG) && reg_wdata[CFG_RST_B] && !rst_busy;
    wp_wr_ok   = reg_wr && (reg_addr == RA_WP) && !wp_q[WPB_TIGHT] && !rst_busy;
    start_data = reg_wdata[OPB_CMD] ? cmd_q :
                 reg_wdata[OPB_ADR] ? addr_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      buf_q  <= '0;
      cs_q   <= '0;
      cfg_q  <= '0;
      wlo_q  <= '0;
      whi_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CMD:  cmd_q  <= reg_wdata;
        RA_ADDR: addr_q <= reg_wdata;
        RA_BSEL: begin
          buf_q <= reg_wdata[BSEL_BUF_W-1:0];
          cs_q  <= reg_wdata[BSEL_CS_LSB +: BSEL_CS_W];
        end
        RA_CFG: begin
          cfg_q <= reg_wdata[CFG_W-1:0];
          cfg_q[CFG_RST_B] <= 1'b0;
        end
        RA_WLO:  wlo_q <= reg_wdata;
        RA_WHI:  whi_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (rst_busy) begin
      wp_q   <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (wp_wr_ok) wp_q <= reg_wdata[WP_W-1:0];
      if (finish)       done_q <= 1'b1;
      else if (wr_trig) done_q <= done_q & reg_wdata[TRIG_DONE_B];
      if (busy_hit || refused) fail_q <= 1'b1;
      else if (wr_trig)        fail_q <= fail_q & reg_wdata[TRIG_FAIL_B];
    end
  end

  always_comb begin
    cfg_rd = cfg_q;
    cfg_rd[CFG_RST_B] = rst_busy;
    reg_rdata = '0;
    case (reg_addr)
      RA_TRIG: begin
        reg_rdata[OP_N-1:0]   = cur_op;
        reg_rdata[TRIG_DONE_B] = done_q;
        reg_rdata[TRIG_FAIL_B] = fail_q;
      end
      RA_CMD:  reg_rdata = cmd_q;
      RA_ADDR: reg_rdata = addr_q;
      RA_BSEL: begin
        reg_rdata[BSEL_BUF_W-1:0] = buf_q;
        reg_rdata[BSEL_CS_LSB +: BSEL_CS_W] = cs_q;
      end
      RA_CFG:  reg_rdata[CFG_W-1:0] = cfg_rd;
      RA_WP:   reg_rdata[WP_W-1:0] = wp_q;
      RA_WLO:  reg_rdata = wlo_q;
      RA_WHI:  reg_rdata = whi_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_BUSY_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_hit && !rst_busy) |=> fail_q); // R5
  AST_TIGHT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q[WPB_TIGHT] && !rst_busy && !sw_rst_req) |=> (wp_q == $past(wp_q))); // R10
  AST_REFUSE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> (idle && fail_q)); // R9
endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
  import nand_eng_pkg::*;
#(
  parameter int NCS        = 4,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              nand_op_valid,
  input  logic              nand_op_ready,
  output logic [OP_N-1:0]   nand_op_code,
  output logic [REG_W-1:0]  nand_op_data,
  input  logic              nand_done,
  input  logic              nand_rb,
  output logic [NCS-1:0]    nand_ce_n,
  output logic              irq
);
  logic              idle, finish, start, sw_rst_req, rst_busy, refuse;
  logic              done_q, fail_q;
  logic [REG_W-1:0]  start_data, cmd_q, addr_q, wlo_q, whi_q;
  logic [WP_W-1:0]   wp_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [BSEL_CS_W-1:0] cs_q;
  logic [OP_N-1:0]   cur_op, code_w;

  nand_eng_rstctl #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .start(sw_rst_req), .busy(rst_busy)
  );

  nand_eng_guard u_guard (
    .req_op(reg_wdata[OP_N-1:0]), .cmd_val(cmd_q), .blk(addr_q),
    .wp_mode(wp_q), .win_lo(wlo_q), .win_hi(whi_q), .refuse(refuse)
  );

  nand_eng_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle(idle),
    .finish(finish), .cur_op(cur_op), .rst_busy(rst_busy), .refuse(refuse),
    .start(start), .start_data(start_data), .sw_rst_req(sw_rst_req),
    .cmd_q(cmd_q), .addr_q(addr_q), .wp_q(wp_q), .wlo_q(wlo_q),
    .whi_q(whi_q), .cfg_q(cfg_q), .cs_q(cs_q), .done_q(done_q), .fail_q(fail_q)
  );

  nand_eng_seq u_seq (
    .clk(clk), .rst_n(rst_n), .abort(rst_busy), .start(start),
    .start_op(reg_wdata[OP_N-1:0]), .start_data(start_data),
    .op_ready(nand_op_ready), .nand_done(nand_done), .nand_rb(nand_rb),
    .op_valid(nand_op_valid), .op_code(code_w), .op_data(nand_op_data),
    .idle(idle), .finish(finish)
  );

  assign nand_op_code = code_w;

  logic [OP_N-1:0] run_op_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run_op_q <= '0;
    else if (rst_busy || finish)   run_op_q <= '0;
    else if (start)                run_op_q <= reg_wdata[OP_N-1:0];
  end
  assign cur_op = run_op_q;

  for (genvar i = 0; i < NCS; i++) begin : g_ce
    assign nand_ce_n[i] = !(cfg_q[CFG_CE_B] && (cs_q == BSEL_CS_W'(i)));
  end

  assign irq = done_q && !cfg_q[CFG_MASK_B];

  AST_DONE_AFTER_RB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(nand_rb)); // R3
  AST_CE_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[CFG_MASK_B] |-> !irq); // R4
  AST_FAIL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start && !$past(finish)) |=> !$rose(done_q)); // R9
endmodule

// File: tb/sim_nand_op_engine.sv
module sim_nand_op_engine;
  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic op_valid, op_ready = 1, nand_done = 0, nand_rb = 1, irq;
  logic [5:0] op_code;
  logic [15:0] op_data;
  logic [3:0] ce_n;
  int checks = 0, errors = 0;
  logic [21:0] expq[$];
  bit finished = 0;

  always #4 clk = ~clk;

  nand_op_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nand_op_valid(op_valid),
    .nand_op_ready(op_ready), .nand_op_code(op_code), .nand_op_data(op_data),
    .nand_done(nand_done), .nand_rb(nand_rb), .nand_ce_n(ce_n), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic trig(logic [5:0] op, logic [15:0] data, bit expect_op);
    if (expect_op) expq.push_back({op, data});
    wr(3'd0, {10'd0, op});
  endtask

  task automatic wait_done();
    logic [15:0] v;
    for (int i = 0; i < 100; i++) begin
      rd(3'd0, v);
      if (v[15]) return;
    end
  endtask

  // monitor: compare offered operations against scoreboard
  initial forever begin
    @(negedge clk);
    if (op_valid && op_ready) begin
      if (expq.size() == 0) chk("R2 unexpected op", {10'd0, op_code, op_data}, 32'hFFFF_FFFF);
      else begin
        logic [21:0] e;
        e = expq.pop_front();
        chk("R2 op code/data", {10'd0, op_code, op_data}, {10'd0, e});
      end
    end
  end

  // flash stub
  initial forever begin
    @(negedge clk);
    if (op_valid && op_ready) begin
      nand_rb = 0;
      repeat (3) @(negedge clk);
      nand_done = 1;
      @(negedge clk); nand_done = 0;
      repeat (5) @(negedge clk);
      nand_rb = 1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v); chk("R1 reg reset", v, 0);
    end
    chk("R1 irq", irq, 0); chk("R1 valid", op_valid, 0); chk("R1 ce_n", ce_n, 4'hF);

    // R2/R3 command cycle
    wr(3'd1, 16'h0070);
    trig(6'b000001, 16'h0070, 1);
    repeat (6) @(negedge clk);
    rd(3'd0, v); chk("R3 done not before rb", v[15], 0); chk("R2 busy readback", v[5:0], 6'b000001);
    wait_done();
    rd(3'd0, v); chk("R3 done set", v, 16'h8000);
    chk("R4 irq unmasked", irq, 1);
    wr(3'd0, 16'h8000); rd(3'd0, v); chk("R3 write 1 keeps done", v[15], 1);
    repeat (10) @(negedge clk); chk("R6 no op from zero trigger", op_valid, 0);
    wr(3'd0, 16'h0000); rd(3'd0, v); chk("R3 write 0 clears", v[15], 0);
    chk("R4 irq low", irq, 0);

    // R4 masked address cycle
    wr(3'd4, 16'h0010); wr(3'd2, 16'h1234);
    trig(6'b000010, 16'h1234, 1);
    wait_done();
    rd(3'd0, v); chk("R3 done addr op", v[15], 1);
    chk("R4 irq masked", irq, 0);
    wr(3'd4, 16'h0000); @(negedge clk); chk("R4 irq unmask", irq, 1);
    wr(3'd0, 16'h0000);

    // R5 busy trigger
    trig(6'b010000, 16'h0000, 1);
    trig(6'b100000, 16'h0000, 0);
    rd(3'd0, v); chk("R5 fail set", v[14], 1);
    wait_done();
    rd(3'd0, v); chk("R5 fail sticky", v[15:14], 2'b11);
    wr(3'd0, 16'h0000); rd(3'd0, v); chk("R5 fail cleared", v, 0);

    // R6 multi-bit trigger
    wr(3'd0, 16'h0003);
    repeat (10) @(negedge clk);
    rd(3'd0, v); chk("R6 multi-bit ignored", v, 0); chk("R6 no valid", op_valid, 0);

    // R11 readback, R7 chip enable
    wr(3'd3, 16'hFFFF); rd(3'd3, v); chk("R11 bsel bits", v, 16'h0067);
    wr(3'd4, 16'hFFBF); rd(3'd4, v); chk("R11 cfg bits", v, 16'h0FBF);
    chk("R7 ce cs3", ce_n, 4'b0111);
    wr(3'd3, 16'h0040); @(negedge clk); chk("R7 ce cs2", ce_n, 4'b1011);
    wr(3'd4, 16'h0000); @(negedge clk); chk("R7 ce off", ce_n, 4'hF);

    // R9 protection
    wr(3'd2, 16'd15);
    trig(6'b000100, 0, 0); repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R9 locked program refused", v, 16'h4000);
    wr(3'd0, 0);
    wr(3'd5, 16'h0004); wr(3'd6, 16'd10); wr(3'd7, 16'd20);
    wr(3'd2, 16'd5);
    trig(6'b000100, 0, 0); repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R9 below window refused", v, 16'h4000);
    wr(3'd0, 0);
    wr(3'd2, 16'd15);
    trig(6'b000100, 0, 1); wait_done();
    rd(3'd0, v); chk("R9 program in window", v, 16'h8000);
    wr(3'd0, 0);
    wr(3'd1, 16'h0060); wr(3'd2, 16'd25);
    trig(6'b000001, 0, 0); repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R9 erase outside refused", v, 16'h4000);
    wr(3'd0, 0);
    wr(3'd2, 16'd20);
    trig(6'b000001, 16'h0060, 1); wait_done();
    rd(3'd0, v); chk("R9 erase at upper bound", v, 16'h8000);
    wr(3'd0, 0);

    // R10 lock-tight
    wr(3'd5, 16'h0001); wr(3'd5, 16'h0004);
    rd(3'd5, v); chk("R10 wp frozen", v, 16'h0001);
    trig(6'b000100, 0, 0); repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R9 tight refuses program", v, 16'h4000);

    // R8 soft reset aborting a held operation
    op_ready = 0;
    wr(3'd0, 0);
    trig(6'b001000, 0, 0);
    repeat (3) @(negedge clk);
    chk("R2 valid held while not ready", op_valid, 1);
    wr(3'd4, 16'h0040);
    rd(3'd4, v); chk("R8 reset bit reads 1", v[6], 1);
    chk("R8 op aborted", op_valid, 0);
    trig(6'b000001, 0, 0);
    rd(3'd0, v); chk("R8 trigger ignored in reset", v, 0);
    op_ready = 1;
    repeat (12) @(negedge clk);
    rd(3'd4, v); chk("R8 reset bit self clears", v[6], 0);
    rd(3'd5, v); chk("R8/R10 wp released", v, 0);
    chk("R8 no op after reset", op_valid, 0);
    wr(3'd5, 16'h0004); rd(3'd5, v); chk("R10 wp writable", v, 16'h0004);

    repeat (5) @(negedge clk);
    chk("R2 scoreboard empty", expq.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule